// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a 56-bit physical address by reading up to three 64-bit translation entries from memory. Each table in the tree is one 4096-byte page of 512 entries. The root table's page number comes from a software-written root register, which arrives here as an input. Nine bits of the virtual page number select the entry at each level, starting with the most significant group.

One request is handled at a time. The walker has a single read port toward memory with a valid/ready request channel and a data return. The read port allows only one outstanding read. The result is either the physical address plus the low flag bits of the leaf entry, or a page-fault indication.

The walker stops at the first entry that is not usable at its level. Only 4 KiB pages are supported, so a leaf entry above the last level is a fault.

Top module: `pt_walker3`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `resp_valid` and `mem_req_valid` are 0.
- R2: The first read goes to `{root_ppn, va[38:30], 3'b000}`. The second read uses the page number in bits 53:10 of the first entry with `va[29:21]`. The third read uses the page number from the second entry with `va[20:12]`. Every read address is 8-byte aligned.
- R3: Entry flags are bit 0 valid, bit 1 read, bit 2 write, bit 3 execute and bit 4 user. A valid entry at the third level with read or execute set gives `resp_fault`=0, `resp_pa = {pte[53:10], va[11:0]}` and `resp_flags = pte[9:0]`.
- R4: An entry with the valid bit clear, at any level, ends the walk with `resp_fault`=1 and `resp_pa`=0, and no further reads are issued.
- R5: A valid entry at the first or second level with read or execute set is a fault, and no further reads are issued.
- R6: At the third level, a valid entry with read and execute both clear is a fault. At any level, an entry with write set and read clear is a fault.
- R7: If `va[63:39]` are not all equal to `va[38]`, the request faults without any memory read.
- R8: `req_ready` is 1 only while no walk is in progress and no response is being given. Requests are answered in the order they were accepted.
- R9: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. No new read is issued before the previous data has returned.
- R10: Each accepted request gives exactly one single-cycle `resp_valid` pulse. `resp_acc` on that pulse echoes the request's `req_acc`.
- R11: An entry with any of bits 63:54 set is a fault at any level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken on this edge |
| req_va | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access type tag, echoed back with the response |
| root_ppn | input | 44 | Page number of the root table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| resp_valid | output | 1 | Translation result, one cycle |
| resp_fault | output | 1 | Page fault |
| resp_pa | output | 56 | Physical address, zero on a fault |
| resp_flags | output | 10 | Leaf entry bits 9:0, zero on a fault |
| resp_acc | output | 2 | Echoed access type |

## Verification
Two events can fall in the same cycle. One is the response pulse for a finished walk. The other is the next request, which the bench already holds on the request port. The bench drives requests back to back, so a new request is always waiting while the previous walk finishes. A second pass adds pseudo-random stalls on `mem_req_ready` and a few cycles of read latency. The scoreboard expects exactly one response per request and in order, with the number of memory reads predicted by its own walk of the bench memory. A request that was taken during the response cycle would show up as a wrong read count or a shifted result.

// File: rtl/pt_walk_pkg.sv
`timescale 1ns/1ps
package pt_walk_pkg;
  typedef enum logic [1:0] {
    WS_IDLE,
    WS_FETCH,
    WS_RESP
  } walk_st_e;

  typedef enum logic [1:0] {
    PK_BAD,
    PK_PTR,
    PK_LEAF
  } pte_kind_e;
endpackage

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen #(
  parameter int IDX_W  = 9,
  parameter int LEVELS = 3,
  parameter int PPN_W  = 44,
  parameter int OFF_W  = 12,
  localparam int VPN_W = IDX_W * LEVELS,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [VPN_W-1:0]       vpn,
  input  logic [LVL_W-1:0]       lvl,
  input  logic [PPN_W-1:0]       base,
  output logic [PPN_W+OFF_W-1:0] addr
);
  localparam int SCALE_W = OFF_W - IDX_W;

  logic [IDX_W-1:0] idx_arr [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_slice
    assign idx_arr[l] = vpn[l*IDX_W +: IDX_W];
  end

  assign addr = {base, idx_arr[lvl], {SCALE_W{1'b0}}};
endmodule

// File: rtl/ptw_pte_classify.sv
`timescale 1ns/1ps
module ptw_pte_classify
  import pt_walk_pkg::*;
#(
  parameter int PTE_W = 64,
  parameter int PPN_W = 44,
  parameter int FLG_W = 10
) (
  input  logic [PTE_W-1:0] pte,
  output pte_kind_e        kind,
  output logic [PPN_W-1:0] ppn,
  output logic [FLG_W-1:0] flags
);
  localparam int RSV_LSB = FLG_W + PPN_W;

  logic v_b, r_b, w_b, x_b, rsv_set;

  assign v_b     = pte[0];
  assign r_b     = pte[1];
  assign w_b     = pte[2];
  assign x_b     = pte[3];
  assign rsv_set = |pte[PTE_W-1:RSV_LSB];
  assign ppn     = pte[RSV_LSB-1:FLG_W];
  assign flags   = pte[FLG_W-1:0];

  always_comb begin
    if (!v_b || rsv_set || (w_b && !r_b)) kind = PK_BAD;
    else if (r_b || x_b)                  kind = PK_LEAF;
    else                                  kind = PK_PTR;
  end
endmodule

// File: rtl/pt_walker3.sv
`timescale 1ns/1ps
module pt_walker3
  import pt_walk_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 56,
  parameter int PTE_W  = 64,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 3,
  parameter int OFF_W  = 12,
  parameter int FLG_W  = 10,
  parameter int ACC_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [ACC_W-1:0] req_acc,
  input  logic [PA_W-OFF_W-1:0] root_ppn,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             resp_valid,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_pa,
  output logic [FLG_W-1:0] resp_flags,
  output logic [ACC_W-1:0] resp_acc
);
  localparam int PPN_W = PA_W - OFF_W;
  localparam int VPN_W = IDX_W * LEVELS;
  localparam int XL_W  = OFF_W + VPN_W;
  localparam int LVL_W = $clog2(LEVELS);
  localparam int HI_W  = VA_W - XL_W + 1;

  walk_st_e         st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [XL_W-1:0]  va_q;

  logic [VPN_W-1:0] walk_vpn;
  logic [LVL_W-1:0] next_lvl;
  logic [PPN_W-1:0] next_base;
  logic [PA_W-1:0]  next_addr;
  logic [HI_W-1:0]  va_hi;
  logic             canon;
  logic             last;
  logic             pte_fault;
  pte_kind_e        pte_kind;
  logic [PPN_W-1:0] pte_ppn;
  logic [FLG_W-1:0] pte_flags;

  assign req_ready = (st_q == WS_IDLE);
  assign va_hi     = req_va[VA_W-1:XL_W-1];
  assign canon     = (&va_hi) || !(|va_hi);
  assign last      = (lvl_q == '0);
  assign walk_vpn  = (st_q == WS_IDLE) ? req_va[XL_W-1:OFF_W] : va_q[XL_W-1:OFF_W];
  assign next_lvl  = (st_q == WS_IDLE) ? LVL_W'(LEVELS-1) : LVL_W'(lvl_q - 1'b1);
  assign next_base = (st_q == WS_IDLE) ? root_ppn : pte_ppn;
  assign pte_fault = (pte_kind == PK_BAD) ||
                     (pte_kind == PK_LEAF && !last) ||
                     (pte_kind == PK_PTR && last);

  ptw_addr_gen #(
    .IDX_W(IDX_W), .LEVELS(LEVELS), .PPN_W(PPN_W), .OFF_W(OFF_W)
  ) u_addr (
    .vpn(walk_vpn), .lvl(next_lvl), .base(next_base), .addr(next_addr)
  );

  ptw_pte_classify #(
    .PTE_W(PTE_W), .PPN_W(PPN_W), .FLG_W(FLG_W)
  ) u_cls (
    .pte(mem_rsp_data), .kind(pte_kind), .ppn(pte_ppn), .flags(pte_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= WS_IDLE;
      lvl_q         <= '0;
      va_q          <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      resp_valid    <= 1'b0;
      resp_fault    <= 1'b0;
      resp_pa       <= '0;
      resp_flags    <= '0;
      resp_acc      <= '0;
    end else begin
      case (st_q)
        WS_IDLE: begin
          if (req_valid) begin
            va_q     <= req_va[XL_W-1:0];
            resp_acc <= req_acc;
            if (!canon) begin
              st_q       <= WS_RESP;
              resp_valid <= 1'b1;
              resp_fault <= 1'b1;
              resp_pa    <= '0;
              resp_flags <= '0;
            end else begin
              st_q          <= WS_FETCH;
              lvl_q         <= next_lvl;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= next_addr;
            end
          end
        end
        WS_FETCH: begin
          if (mem_req_valid) begin
            if (mem_req_ready) mem_req_valid <= 1'b0;
          end else if (mem_rsp_valid) begin
            if (pte_fault) begin
              st_q       <= WS_RESP;
              resp_valid <= 1'b1;
              resp_fault <= 1'b1;
              resp_pa    <= '0;
              resp_flags <= '0;
            end else if (pte_kind == PK_LEAF) begin
              st_q       <= WS_RESP;
              resp_valid <= 1'b1;
              resp_fault <= 1'b0;
              resp_pa    <= {pte_ppn, va_q[OFF_W-1:0]};
              resp_flags <= pte_flags;
            end else begin
              lvl_q         <= next_lvl;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= next_addr;
            end
          end
        end
        default: begin
          resp_valid <= 1'b0;
          st_q       <= WS_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pt_walker3_checker.sv
`timescale 1ns/1ps
module pt_walker3_checker #(
  parameter int PA_W  = 56,
  parameter int FLG_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             resp_valid,
  input logic             resp_fault,
  input logic [PA_W-1:0]  resp_pa,
  input logic [FLG_W-1:0] resp_flags
);
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R2

  AST_LEAF_USABLE: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_fault) |-> (resp_flags[0] && (resp_flags[1] || resp_flags[3]) && !(resp_flags[2] && !resp_flags[1]))); // R3

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (resp_pa == '0)); // R4

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid || resp_valid) |-> !req_ready); // R8

  AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid); // R10
endmodule

bind pt_walker3 pt_walker3_checker #(.PA_W(PA_W), .FLG_W(FLG_W)) u_pt_walker3_checker (
  .clk(clk), .rst(rst), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_pa(resp_pa), .resp_flags(resp_flags)
);

// File: tb/pt_walker3_bench.sv
`timescale 1ns/1ps
module pt_walker3_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic [43:0] root_ppn = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        resp_valid;
  logic        resp_fault;
  logic [55:0] resp_pa;
  logic [9:0]  resp_flags;
  logic [1:0]  resp_acc;

  always #4 clk = ~clk;

  pt_walker3 u_pt_walker3 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_acc(req_acc),
    .root_ppn(root_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_pa(resp_pa),
    .resp_flags(resp_flags), .resp_acc(resp_acc)
  );

  typedef struct {
    logic        fault;
    logic [55:0] pa;
    logic [9:0]  flags;
    logic [1:0]  acc;
    int          nreads;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic [63:0] mem [logic [55:0]];
  int n_checks = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  bit stall_on = 1'b0;
  int lat = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit pend = 1'b0;
  int dly = 0;
  logic [55:0] paddr = '0;
  bit done = 1'b0;

  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [9:0] fl);
    return {10'b0, ppn, fl};
  endfunction

  function automatic logic [63:0] mem_rd(input logic [55:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // independent walk over the bench memory, from the requirements
  function automatic void model(input logic [63:0] va, input logic [43:0] root,
                                output logic f, output logic [55:0] pa,
                                output logic [9:0] fl, output int nr);
    logic [43:0] ppn;
    logic [63:0] pte;
    f = 1'b0; pa = '0; fl = '0; nr = 0;
    if (va[63:39] != {25{va[38]}}) begin f = 1'b1; return; end   // R7
    ppn = root;
    for (int lv = 2; lv >= 0; lv--) begin
      pte = mem_rd({ppn, va[12+9*lv +: 9], 3'b000});             // R2
      nr++;
      if (!pte[0] || pte[63:54] != 0 || (pte[2] && !pte[1])) begin f = 1'b1; return; end // R4 R6 R11
      if (pte[1] || pte[3]) begin
        if (lv != 0) f = 1'b1;                                     // R5
        else begin pa = {pte[53:10], va[11:0]}; fl = pte[9:0]; end // R3
        return;
      end
      if (lv == 0) begin f = 1'b1; return; end                    // R6
      ppn = pte[53:10];
    end
  endfunction

  task automatic check(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  // driver: called at a negedge, returns at a negedge
  task automatic send(input logic [63:0] va, input logic [43:0] root, input logic [1:0] acc, input string tag);
    exp_t e;
    model(va, root, e.fault, e.pa, e.flags, e.nreads);
    e.acc = acc;
    e.tag = tag;
    exp_q.push_back(e);
    req_valid = 1'b1; req_va = va; root_ppn = root; req_acc = acc;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, $sformatf("R8 %s busy after accept: req_ready act=%0b exp=0", tag, req_ready));
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (resp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 response with no request pending: act=1 exp=0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(resp_fault == e.fault && resp_pa == e.pa && resp_flags == e.flags &&
                resp_acc == e.acc && rd_cnt == e.nreads,
                $sformatf("R3/R4/R10 %s: act fault=%0b pa=%h fl=%h acc=%0d reads=%0d exp fault=%0b pa=%h fl=%h acc=%0d reads=%0d",
                          e.tag, resp_fault, resp_pa, resp_flags, resp_acc, rd_cnt,
                          e.fault, e.pa, e.flags, e.acc, e.nreads));
        end
        rd_cnt = 0;
      end
      mem_rsp_valid = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready = stall_on ? lfsr[0] : 1'b1;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_rd(paddr);
          pend = 1'b0;
        end else dly--;
      end else if (mem_req_valid && mem_req_ready) begin
        pend  = 1'b1;
        paddr = mem_req_addr;
        dly   = lat;
        rd_cnt++;
      end
    end
  end

  task automatic run_set(input string pfx);
    send(64'h0000_0000_4040_3123, 44'h100, 2'd0, {pfx, " R3 rw leaf"});
    send(64'hFFFF_FFFF_FFFF_FFFF, 44'h100, 2'd2, {pfx, " R3 exec leaf max idx"});
    send(64'h0000_0001_4000_0000, 44'h100, 2'd1, {pfx, " R4 invalid root"});
    send(64'h0000_0000_4040_4000, 44'h100, 2'd0, {pfx, " R4 invalid last"});
    send(64'h0000_0001_8000_0000, 44'h100, 2'd1, {pfx, " R5 leaf level1"});
    send(64'h0000_0000_40E0_0000, 44'h100, 2'd2, {pfx, " R5 leaf level2"});
    send(64'h0000_0000_4040_8000, 44'h100, 2'd0, {pfx, " R6 pointer at last"});
    send(64'h0000_0000_4040_9000, 44'h100, 2'd1, {pfx, " R6 write only"});
    send(64'h0000_0000_4040_A000, 44'h100, 2'd2, {pfx, " R11 reserved bit"});
    send(64'h0000_0080_0000_0000, 44'h100, 2'd3, {pfx, " R7 bit39 set"});
    send(64'h8000_0000_0000_1000, 44'h100, 2'd0, {pfx, " R7 bit63 set"});
    send(64'h0000_0000_4040_3FFF, 44'h600, 2'd1, {pfx, " R2 other root"});
  endtask

  initial begin
    mem[{44'h100, 9'd1,   3'b0}] = mk_pte(44'h200, 10'h001);
    mem[{44'h200, 9'd2,   3'b0}] = mk_pte(44'h300, 10'h001);
    mem[{44'h300, 9'd3,   3'b0}] = mk_pte(44'hABCDE, 10'h0D7);
    mem[{44'h100, 9'd511, 3'b0}] = mk_pte(44'h400, 10'h001);
    mem[{44'h400, 9'd511, 3'b0}] = mk_pte(44'h500, 10'h001);
    mem[{44'h500, 9'd511, 3'b0}] = mk_pte(44'hFFF_FFFF_FFFF, 10'h009);
    mem[{44'h100, 9'd6,   3'b0}] = mk_pte(44'h123, 10'h003);
    mem[{44'h200, 9'd7,   3'b0}] = mk_pte(44'h777, 10'h00B);
    mem[{44'h300, 9'd8,   3'b0}] = mk_pte(44'h888, 10'h001);
    mem[{44'h300, 9'd9,   3'b0}] = mk_pte(44'h999, 10'h005);
    mem[{44'h300, 9'd10,  3'b0}] = mk_pte(44'hAAA, 10'h003) | 64'h1000_0000_0000_0000;
    mem[{44'h600, 9'd1,   3'b0}] = mk_pte(44'h200, 10'h001);

    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(req_ready == 1'b1, $sformatf("R1 req_ready act=%0b exp=1", req_ready));
    check(resp_valid == 1'b0, $sformatf("R1 resp_valid act=%0b exp=0", resp_valid));
    check(mem_req_valid == 1'b0, $sformatf("R1 mem_req_valid act=%0b exp=0", mem_req_valid));

    run_set("plain");
    stall_on = 1'b1;
    lat = 3;
    run_set("stall");   // R9 held reads under back-pressure

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, $sformatf("R10 pending responses act=%0d exp=0", exp_q.size()));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R8 watchdog expired: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule